// File: doc/BRIEF.md
# Windowed Exposure Statistics Grid

This block measures scene brightness for an exposure controller. It watches a stream of pixels framed by a frame-valid and a line-valid signal and tracks each pixel's column and row itself. The active image, whose width and height are programmable, is cut into a 5 x 5 grid of windows. Every pixel that passes the region-of-interest test adds its value to its window's sum and increments that window's pixel count.

The region of interest is one inclusion rectangle minus one exclusion rectangle, both given as inclusive coordinates. When a frame ends, the 25 sums and counts are copied into a shadow bank and a one-cycle done pulse is raised. Firmware can then read the shadow bank by window number while the next frame is accumulated.

Top module: `lumaGridStats`

## Requirements
- R1: After reset every window reads a sum and count of 0, and `statDone` is low.
- R2: A pixel's x is the number of valid pixels before it in its line, starting at 0. Its y is the number of completed lines, where a line completes when `lineValid` falls, starting at 0 in each frame. Its window column is min(x / floor(W/5), 4), or 4 when floor(W/5) is 0. The window row follows the same rule using y and H. The window number is row*5 + column.
- R3: Each window holds the sum of the values of its counted pixels and the number of those pixels.
- R4: A pixel passes inclusion when incX0 <= x <= incX1 and incY0 <= y <= incY1. If incX0 > incX1 or incY0 > incY1, the inclusion rectangle is disabled and every pixel passes inclusion.
- R5: A pixel inside the exclusion rectangle (same inclusive test using the exc bounds) is not counted, even if it passes inclusion. If excX0 > excX1 or excY0 > excY1, nothing is excluded.
- R6: A pixel is counted only when `frameValid` and `lineValid` are both high, x < W and y < H. Pixels outside the image size have no effect.
- R7: The accumulators restart on the rising edge of `frameValid`. A pixel presented in that same cycle is counted as pixel (0,0) of the new frame.
- R8: When `frameValid` falls, the totals are copied to the shadow bank. `statDone` is high for exactly the one cycle after the edge where the fall is sampled.
- R9: Reads via `rdIdx` (0..24) return the shadow bank, which stays unchanged until the next done pulse. An index of 25 to 31 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| frameValid | input | 1 | High for the duration of a frame |
| lineValid | input | 1 | High while pixels of a line are presented |
| pixData | input | 12 | Pixel brightness |
| cfgWidth | input | 12 | Image width W |
| cfgHeight | input | 12 | Image height H |
| incX0 | input | 12 | Inclusion first column |
| incX1 | input | 12 | Inclusion last column |
| incY0 | input | 12 | Inclusion first row |
| incY1 | input | 12 | Inclusion last row |
| excX0 | input | 12 | Exclusion first column |
| excX1 | input | 12 | Exclusion last column |
| excY0 | input | 12 | Exclusion first row |
| excY1 | input | 12 | Exclusion last row |
| rdIdx | input | 5 | Window number to read |
| rdSum | output | 32 | Frozen brightness sum of the selected window |
| rdCount | output | 20 | Frozen pixel count of the selected window |
| statDone | output | 1 | One-cycle pulse after results are frozen |

## Verification
Frame start can coincide with a pixel. In that cycle the accumulator clear and the first accumulation meet, and the row and column counters must restart while the pixel is binned. The bench provokes this by raising `frameValid` and `lineValid` at the same edge in several frames. It judges the result by comparing all 25 frozen sums and counts against arithmetic totals that include pixel (0,0). Reads of the previous frame's results in the middle of a new frame show that the freeze and the new accumulation do not disturb each other.

// File: rtl/lumaGridPkg.sv
package lumaGridPkg;
  localparam int GRID_N  = 5;
  localparam int NUM_WIN = GRID_N * GRID_N;

  typedef struct packed {
    logic clearAcc;   // first cycle of a frame
    logic latchRes;   // frame has just ended
    logic pixValid;   // a pixel is present this cycle
  } gridStrobe_t;
endpackage

// File: rtl/lumaGridCtrl.sv
module lumaGridCtrl
  import lumaGridPkg::*;
#(
  parameter int COORD_W = 12
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               frameValid,
  input  logic               lineValid,
  output gridStrobe_t        strobe,
  output logic [COORD_W-1:0] curCol,
  output logic [COORD_W-1:0] curRow,
  output logic               statDone
);
  logic fvPrev, lvPrev;
  logic frameRise, frameFall, lineFall;
  logic [COORD_W-1:0] colReg, rowReg;

  assign frameRise = frameValid & ~fvPrev;
  assign frameFall = ~frameValid & fvPrev;
  assign lineFall  = lvPrev & ~lineValid;

  // the frame-start cycle sees coordinate zero regardless of stale counters
  assign curCol = frameRise ? '0 : colReg;
  assign curRow = frameRise ? '0 : rowReg;

  assign strobe.clearAcc = frameRise;
  assign strobe.latchRes = frameFall;
  assign strobe.pixValid = frameValid & lineValid;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      fvPrev   <= 1'b0;
      lvPrev   <= 1'b0;
      statDone <= 1'b0;
      colReg   <= '0;
      rowReg   <= '0;
    end else begin
      fvPrev   <= frameValid;
      lvPrev   <= lineValid;
      statDone <= frameFall;
      if (strobe.pixValid)  colReg <= curCol + 1'b1;
      else if (lineFall)    colReg <= '0;
      else                  colReg <= curCol;
      if (lineFall)         rowReg <= curRow + 1'b1;
      else                  rowReg <= curRow;
    end
  end
endmodule

// File: rtl/lumaGridData.sv
module lumaGridData
  import lumaGridPkg::*;
#(
  parameter int PIX_W   = 12,
  parameter int COORD_W = 12,
  parameter int SUM_W   = 32,
  parameter int CNT_W   = 20
) (
  input  logic               clk,
  input  logic               rstN,
  input  gridStrobe_t        strobe,
  input  logic [COORD_W-1:0] curCol,
  input  logic [COORD_W-1:0] curRow,
  input  logic [PIX_W-1:0]   pixData,
  input  logic [COORD_W-1:0] cfgWidth,
  input  logic [COORD_W-1:0] cfgHeight,
  input  logic [COORD_W-1:0] incX0,
  input  logic [COORD_W-1:0] incX1,
  input  logic [COORD_W-1:0] incY0,
  input  logic [COORD_W-1:0] incY1,
  input  logic [COORD_W-1:0] excX0,
  input  logic [COORD_W-1:0] excX1,
  input  logic [COORD_W-1:0] excY0,
  input  logic [COORD_W-1:0] excY1,
  input  logic [4:0]         rdIdx,
  output logic [SUM_W-1:0]   rdSum,
  output logic [CNT_W-1:0]   rdCount
);
  localparam int THR_W = COORD_W + 3;

  logic [COORD_W-1:0] winW, winH;
  logic [GRID_N-2:0]  colPass, rowPass;
  logic [2:0]         colBin, rowBin;
  logic [4:0]         winIdx;
  logic               incOn, excOn, incHit, excHit, inImage, keep;

  logic [SUM_W-1:0] shadowSum [NUM_WIN];
  logic [CNT_W-1:0] shadowCnt [NUM_WIN];

  assign winW = cfgWidth  / COORD_W'(GRID_N);
  assign winH = cfgHeight / COORD_W'(GRID_N);

  // boundaries k*window size; leftover pixels land in the last bin
  for (genvar k = 1; k < GRID_N; k++) begin : gThr
    assign colPass[k-1] = {3'b000, curCol} >= THR_W'(k) * {3'b000, winW};
    assign rowPass[k-1] = {3'b000, curRow} >= THR_W'(k) * {3'b000, winH};
  end

  assign colBin = 3'($countones(colPass));
  assign rowBin = 3'($countones(rowPass));
  assign winIdx = 5'(rowBin) * 5'd5 + 5'(colBin);

  assign incOn  = (incX0 <= incX1) && (incY0 <= incY1);
  assign excOn  = (excX0 <= excX1) && (excY0 <= excY1);
  assign incHit = !incOn || (curCol >= incX0 && curCol <= incX1 &&
                             curRow >= incY0 && curRow <= incY1);
  assign excHit = excOn && (curCol >= excX0 && curCol <= excX1 &&
                            curRow >= excY0 && curRow <= excY1);
  assign inImage = (curCol < cfgWidth) && (curRow < cfgHeight);
  assign keep    = strobe.pixValid && inImage && incHit && !excHit;

  for (genvar w = 0; w < NUM_WIN; w++) begin : gWin
    logic [SUM_W-1:0] accSum;
    logic [CNT_W-1:0] accCnt;
    logic             hitW;
    assign hitW = keep && (winIdx == 5'(w));

    always_ff @(posedge clk) begin
      if (!rstN) begin
        accSum       <= '0;
        accCnt       <= '0;
        shadowSum[w] <= '0;
        shadowCnt[w] <= '0;
      end else begin
        if (strobe.clearAcc) begin
          accSum <= hitW ? SUM_W'(pixData) : '0;
          accCnt <= hitW ? CNT_W'(1)       : '0;
        end else if (hitW) begin
          accSum <= accSum + SUM_W'(pixData);
          accCnt <= accCnt + 1'b1;
        end
        if (strobe.latchRes) begin
          shadowSum[w] <= accSum;
          shadowCnt[w] <= accCnt;
        end
      end
    end
  end

  always_comb begin
    rdSum   = '0;
    rdCount = '0;
    if (rdIdx < 5'(NUM_WIN)) begin
      rdSum   = shadowSum[rdIdx];
      rdCount = shadowCnt[rdIdx];
    end
  end
endmodule

// File: rtl/lumaGridStats.sv
module lumaGridStats
  import lumaGridPkg::*;
#(
  parameter int PIX_W   = 12,
  parameter int COORD_W = 12,
  parameter int SUM_W   = 32,
  parameter int CNT_W   = 20
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               frameValid,
  input  logic               lineValid,
  input  logic [PIX_W-1:0]   pixData,
  input  logic [COORD_W-1:0] cfgWidth,
  input  logic [COORD_W-1:0] cfgHeight,
  input  logic [COORD_W-1:0] incX0,
  input  logic [COORD_W-1:0] incX1,
  input  logic [COORD_W-1:0] incY0,
  input  logic [COORD_W-1:0] incY1,
  input  logic [COORD_W-1:0] excX0,
  input  logic [COORD_W-1:0] excX1,
  input  logic [COORD_W-1:0] excY0,
  input  logic [COORD_W-1:0] excY1,
  input  logic [4:0]         rdIdx,
  output logic [SUM_W-1:0]   rdSum,
  output logic [CNT_W-1:0]   rdCount,
  output logic               statDone
);
  gridStrobe_t        strobe;
  logic [COORD_W-1:0] curCol, curRow;

  lumaGridCtrl #(.COORD_W(COORD_W)) uCtrl (
    .clk(clk), .rstN(rstN), .frameValid(frameValid), .lineValid(lineValid),
    .strobe(strobe), .curCol(curCol), .curRow(curRow), .statDone(statDone)
  );

  lumaGridData #(.PIX_W(PIX_W), .COORD_W(COORD_W), .SUM_W(SUM_W), .CNT_W(CNT_W)) uData (
    .clk(clk), .rstN(rstN), .strobe(strobe), .curCol(curCol), .curRow(curRow),
    .pixData(pixData), .cfgWidth(cfgWidth), .cfgHeight(cfgHeight),
    .incX0(incX0), .incX1(incX1), .incY0(incY0), .incY1(incY1),
    .excX0(excX0), .excX1(excX1), .excY0(excY0), .excY1(excY1),
    .rdIdx(rdIdx), .rdSum(rdSum), .rdCount(rdCount)
  );
endmodule

// File: rtl/lumaGridStats_chk.sv
module lumaGridStats_chk #(
  parameter int SUM_W = 32,
  parameter int CNT_W = 20
) (
  input logic             clk,
  input logic             rstN,
  input logic             frameValid,
  input logic [4:0]       rdIdx,
  input logic [SUM_W-1:0] rdSum,
  input logic [CNT_W-1:0] rdCount,
  input logic             statDone
);
  // R8: done is a single-cycle pulse
  assert_done_single_R8: assert property (@(posedge clk) disable iff (!rstN)
    statDone |=> !statDone);

  // R8: done follows a sampled falling edge of frameValid
  assert_done_after_fall_R8: assert property (@(posedge clk) disable iff (!rstN)
    statDone |-> (!$past(frameValid) && $past(frameValid, 2)));

  // R9: frozen results change only together with a done pulse
  assert_results_held_R9: assert property (@(posedge clk) disable iff (!rstN)
    ($stable(rdIdx) && !statDone) |-> ($stable(rdSum) && $stable(rdCount)));

  // R9: indices past the grid read zero
  assert_idx_range_R9: assert property (@(posedge clk) disable iff (!rstN)
    (rdIdx > 5'd24) |-> (rdSum == '0 && rdCount == '0));

  // R3: a window with no counted pixels has no brightness
  assert_empty_window_R3: assert property (@(posedge clk) disable iff (!rstN)
    (rdCount == '0) |-> (rdSum == '0));
endmodule

bind lumaGridStats lumaGridStats_chk #(.SUM_W(SUM_W), .CNT_W(CNT_W)) uChk (
  .clk(clk), .rstN(rstN), .frameValid(frameValid), .rdIdx(rdIdx),
  .rdSum(rdSum), .rdCount(rdCount), .statDone(statDone)
);

// File: tb/lumaGridStats_test.sv
module lumaGridStats_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        frameValid = 1'b0, lineValid = 1'b0;
  logic [11:0] pixData = '0;
  logic [11:0] cfgWidth = 12'd13, cfgHeight = 12'd11;
  logic [11:0] incX0 = 12'd1, incX1 = 12'd0, incY0 = '0, incY1 = '0;
  logic [11:0] excX0 = 12'd1, excX1 = 12'd0, excY0 = '0, excY1 = '0;
  logic [4:0]  rdIdx = '0;
  logic [31:0] rdSum;
  logic [19:0] rdCount;
  logic        statDone;

  int checks = 0, errors = 0;
  longint expSum [25];
  longint expCnt [25];
  longint probeSum = 0;

  always #10 clk = ~clk;

  lumaGridStats uut (
    .clk(clk), .rstN(rstN), .frameValid(frameValid), .lineValid(lineValid),
    .pixData(pixData), .cfgWidth(cfgWidth), .cfgHeight(cfgHeight),
    .incX0(incX0), .incX1(incX1), .incY0(incY0), .incY1(incY1),
    .excX0(excX0), .excX1(excX1), .excY0(excY0), .excY1(excY1),
    .rdIdx(rdIdx), .rdSum(rdSum), .rdCount(rdCount), .statDone(statDone)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int binOf(input int p, input int size);
    int ws = size / 5;
    if (ws == 0) return 4;
    return (p / ws > 4) ? 4 : p / ws;
  endfunction

  function automatic bit counted(input int x, input int y);
    bit incOn = (incX0 <= incX1) && (incY0 <= incY1);
    bit excOn = (excX0 <= excX1) && (excY0 <= excY1);
    bit incHit = !incOn || (x >= incX0 && x <= incX1 && y >= incY0 && y <= incY1);
    bit excHit = excOn && (x >= excX0 && x <= excX1 && y >= excY0 && y <= excY1);
    return (x < cfgWidth) && (y < cfgHeight) && incHit && !excHit;
  endfunction

  task automatic runFrame(input int seed, input int extraX, input int extraY, input bit sameStart);
    for (int w = 0; w < 25; w++) begin expSum[w] = 0; expCnt[w] = 0; end
    @(negedge clk);
    frameValid = 1'b1;
    if (!sameStart) @(negedge clk);
    for (int y = 0; y < cfgHeight + extraY; y++) begin
      if (y == cfgHeight / 2) begin
        // R9: previous frame's window 6 is unchanged mid-frame
        rdIdx = 5'd6; #1;
        chk(rdSum == probeSum, "R9 held during next frame", rdSum, probeSum);
      end
      for (int x = 0; x < cfgWidth + extraX; x++) begin
        int v = (x * 37 + y * 101 + seed * 13) % 4096;
        lineValid = 1'b1;
        pixData = 12'(v);
        if (counted(x, y)) begin
          int wi = binOf(y, cfgHeight) * 5 + binOf(x, cfgWidth);
          expSum[wi] += v;
          expCnt[wi] += 1;
        end
        @(negedge clk);
      end
      lineValid = 1'b0;
      pixData = '0;
      repeat (2) @(negedge clk);
    end
    frameValid = 1'b0;
    @(negedge clk);
    chk(statDone == 1'b1, "R8 done raised", statDone, 1);
    @(negedge clk);
    chk(statDone == 1'b0, "R8 done one cycle", statDone, 0);
    for (int w = 0; w < 25; w++) begin
      rdIdx = 5'(w); #1;
      chk(rdSum == expSum[w], "R2 R3 R4 R5 R6 R7 window sum", rdSum, expSum[w]);
      chk(rdCount == expCnt[w], "R2 R3 R4 R5 R6 R7 window count", rdCount, expCnt[w]);
    end
    probeSum = expSum[6];
    @(negedge clk);
  endtask

  initial begin
    #(20 * 200000);
    errors++; checks++;
    $display("FAIL watchdog actual 0 expected 1");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk(statDone == 1'b0, "R1 done low", statDone, 0);
    for (int w = 0; w < 25; w += 6) begin
      rdIdx = 5'(w); #1;
      chk(rdSum == 0 && rdCount == 0, "R1 zero results", rdSum, 0);
    end

    // full image, no rectangles, leftover columns and rows (R2, R3)
    runFrame(1, 0, 0, 1'b0);
    for (int i = 25; i < 32; i += 3) begin
      rdIdx = 5'(i); #1;
      chk(rdSum == 0 && rdCount == 0, "R9 index past grid", rdSum, 0);
    end
    // inclusion only, pixel in frame-start cycle (R4, R7)
    incX0 = 2; incX1 = 9; incY0 = 1; incY1 = 8;
    runFrame(2, 0, 0, 1'b1);
    // exclusion inside inclusion (R5)
    excX0 = 4; excX1 = 6; excY0 = 3; excY1 = 5;
    runFrame(3, 0, 0, 1'b1);
    // exclusion only, pixels beyond width and height (R5, R6)
    incX0 = 1; incX1 = 0;
    excX0 = 0; excX1 = 3; excY0 = 0; excY1 = 12;
    runFrame(4, 3, 2, 1'b0);
    // exact fit grid (R2)
    cfgWidth = 25; cfgHeight = 20; excX0 = 1; excX1 = 0;
    runFrame(5, 0, 0, 1'b1);
    // one-pixel windows and one-pixel exclusion (R2, R5)
    cfgWidth = 7; cfgHeight = 6;
    excX0 = 1; excX1 = 1; excY0 = 0; excY1 = 0;
    runFrame(6, 0, 0, 1'b1);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule